// File: doc/BRIEF.md
# Synthesizer Configuration Register Port

This block is the serial configuration port of a frequency synthesizer control chip. It holds four 8-bit configuration registers: the low byte of the feedback divider, the top bits of the feedback divider, the reference divider, and a general control register. An external master reaches these registers over a four-wire serial bus with a select, a clock, a data-in line and a data-out line. All four bus pins are sampled into the chip's system clock through two-flop synchronizers. Every bus edge is detected in that domain, so the system clock must run at least four times faster than the serial clock.

Within one select-low frame the bytes alternate between address and value, so several registers can be accessed without raising the select line. Write values are held in a staging copy and are applied together when the select line rises. A commit that includes the feedback divider low byte produces a one-cycle calibration-start pulse. When calibration mode is set, a commit that includes the reference divider also produces the pulse. A low sleep input turns the data-out driver off, resets the shift logic and discards staged writes.

Top module: `synth_cfg_spi`

## Requirements
- R1: Bits are shifted most significant first and sampled on the rising serial clock edge. The first byte after select falls is an address byte: bit 7 set means read, bit 7 clear means write, and bits 6:0 hold the register address. Bytes then alternate address, value, address, value for as long as select stays low.
- R2: A written value has no effect on any register output while select is low. All values staged in one frame take effect together within a few system clocks after select rises.
- R3: After reset all four registers read 0x00. Address 0 holds 8 bits, address 1 holds 2 bits, address 2 holds 6 bits and address 3 holds 4 bits. Unimplemented bits are stored and read as 0.
- R4: On a read, the committed value of the addressed register is shifted out during the value byte, most significant bit first. Each bit changes after a falling serial clock edge. Staged but uncommitted writes are not visible to reads, and addresses above 3 read as 0x00.
- R5: Writes to addresses above 3 change no register.
- R6: The data-out line is driven 0 during address bytes and during the value byte of a write.
- R7: The data-out enable is 1 only while select is low and the sleep input is high.
- R8: A commit that includes address 0 raises the calibration-start output for exactly one system clock. A commit without address 0 or 2 raises no pulse.
- R9: A commit that includes address 2 raises the pulse only when the calibration-mode bit (address 3 bit 2) is 1, taking that bit's value as it stands after the same commit.
- R10: While sleep is low the shift logic is held in reset and the staged writes are discarded, so a select rise that happens during sleep commits nothing. The committed registers keep their values.
- R11: A byte cut short by select rising, and an address byte with no value byte after it, are discarded.
- R12: The divider and control outputs are taken from the committed registers: the feedback divider is {addr1[1:0], addr0[7:0]}, the reference divider is addr2[5:0], squelch-disable is addr3 bit 3, calibration mode is addr3 bit 2, and the output-current code is addr3 bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | 1 = awake, 0 = sleep |
| spiSck | input | 1 | Serial clock from the master |
| spiCsN | input | 1 | Frame select, active low |
| spiMosi | input | 1 | Serial data from the master |
| spiMisoOut | output | 1 | Serial data to the master |
| spiMisoOe | output | 1 | Output enable for the data-out pad driver |
| fbDiv | output | 10 | Committed feedback divider |
| refDiv | output | 6 | Committed reference divider |
| squelchOff | output | 1 | Committed squelch-disable bit |
| calMode | output | 1 | Committed calibration-mode bit |
| outCurrent | output | 2 | Committed output-current code |
| calStart | output | 1 | One-cycle calibration-start pulse |

## Verification
Two events can land in the same system clock: the commit caused by select rising and entry into sleep. The bench drops the sleep input on the same clock on which it raises select after a full write pair. Because sleep takes priority, the bench expects the committed divider to keep its old value and expects no calibration pulse. It then wakes the block and reads the register back to confirm that nothing was lost or applied.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 4;

  // strobes from the bus control to the register datapath
  typedef struct packed {
    logic              stageWr;  // a complete write pair was received
    logic              commit;   // frame closed while awake
    logic              flush;    // sleep: drop staged values
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cfgStrobe_t;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= RESET_VAL;
      else if (g == 0) pipe[g] <= asyncIn;
      else pipe[g] <= pipe[(g == 0) ? 0 : g-1];
    end
  end

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              runEn,
  input  logic              sckS,
  input  logic              csNS,
  input  logic              mosiS,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] lookAddr,
  output cfgStrobe_t        strobe,
  output logic              misoBit,
  output logic              misoOe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W-1);

  logic              sckPrev, csPrev;
  logic              sckRise, sckFall, csRise, csActive;
  logic [CNT_W-1:0]  bitCnt;
  logic              inValue;
  logic              rwReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-2:0] shReg;
  logic [DATA_W-1:0] shNew;
  logic [DATA_W-1:0] txReg;
  logic              stageWrQ;
  logic [ADDR_W-1:0] stageAddrQ;
  logic [DATA_W-1:0] stageDataQ;

  assign sckRise  = sckS & ~sckPrev;
  assign sckFall  = ~sckS & sckPrev;
  assign csRise   = csNS & ~csPrev;
  assign csActive = ~csNS & runEn;
  assign shNew    = {shReg, mosiS};
  assign lookAddr = shNew[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      sckPrev <= sckS;
      csPrev  <= csNS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt     <= '0;
      inValue    <= 1'b0;
      rwReg      <= 1'b0;
      addrReg    <= '0;
      shReg      <= '0;
      txReg      <= '0;
      misoBit    <= 1'b0;
      stageWrQ   <= 1'b0;
      stageAddrQ <= '0;
      stageDataQ <= '0;
    end else if (!csActive) begin
      bitCnt   <= '0;
      inValue  <= 1'b0;
      rwReg    <= 1'b0;
      txReg    <= '0;
      misoBit  <= 1'b0;
      stageWrQ <= 1'b0;
    end else begin
      stageWrQ <= 1'b0;
      if (sckRise) begin
        shReg  <= shNew[DATA_W-2:0];
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == LAST_BIT) begin
          inValue <= ~inValue;
          if (!inValue) begin
            addrReg <= shNew[ADDR_W-1:0];
            rwReg   <= shNew[DATA_W-1];
            txReg   <= shNew[DATA_W-1] ? rdData : '0;
          end else if (!rwReg) begin
            stageWrQ   <= 1'b1;
            stageAddrQ <= addrReg;
            stageDataQ <= shNew;
          end
        end
      end else if (sckFall) begin
        misoBit <= txReg[DATA_W-1];
        txReg   <= {txReg[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_comb begin
    strobe.stageWr = stageWrQ;
    strobe.commit  = csRise & runEn;
    strobe.flush   = ~runEn;
    strobe.addr    = stageAddrQ;
    strobe.data    = stageDataQ;
  end

  assign misoOe = csActive;

  AST_IDLE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !csActive |=> (bitCnt == '0)); // R11
  AST_WRITE_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (csActive && inValue && !rwReg) |-> !misoBit); // R6
  AST_NO_STAGE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> !stageWrQ); // R10
endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
  import synth_cfg_pkg::*;
#(
  parameter int FB_W  = 10,
  parameter int REF_W = 6,
  parameter int CTL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfgStrobe_t        strobeIn,
  input  logic [ADDR_W-1:0] lookAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [FB_W-1:0]   fbDiv,
  output logic [REF_W-1:0]  refDiv,
  output logic              squelchOff,
  output logic              calMode,
  output logic [1:0]        outCurrent,
  output logic              calStart
);
  localparam int FB_HI_W = FB_W - DATA_W;
  localparam int IDX_W   = $clog2(NUM_REGS);
  localparam int A_FB_LO = 0;
  localparam int A_FB_HI = 1;
  localparam int A_REF   = 2;
  localparam int A_CTL   = 3;
  localparam int CAL_MODE_BIT = 2;
  localparam int SQUELCH_BIT  = 3;

  function automatic logic [DATA_W-1:0] regMask(input int idx);
    case (idx)
      A_FB_LO: regMask = '1;
      A_FB_HI: regMask = DATA_W'((1 << FB_HI_W) - 1);
      A_REF:   regMask = DATA_W'((1 << REF_W) - 1);
      default: regMask = DATA_W'((1 << CTL_W) - 1);
    endcase
  endfunction

  logic [NUM_REGS-1:0][DATA_W-1:0] liveReg;
  logic [NUM_REGS-1:0][DATA_W-1:0] stagedReg;
  logic [NUM_REGS-1:0]             pend;
  logic                            wrHit;
  logic [IDX_W-1:0]                wrIdx;
  logic                            modeAfter;

  assign wrHit = strobeIn.stageWr && (strobeIn.addr < ADDR_W'(NUM_REGS));
  assign wrIdx = strobeIn.addr[IDX_W-1:0];
  assign modeAfter = pend[A_CTL] ? stagedReg[A_CTL][CAL_MODE_BIT]
                                 : liveReg[A_CTL][CAL_MODE_BIT];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        liveReg[r]   <= '0;
        stagedReg[r] <= '0;
        pend[r]      <= 1'b0;
      end else if (strobeIn.flush) begin
        pend[r] <= 1'b0;
      end else if (strobeIn.commit) begin
        if (pend[r]) liveReg[r] <= stagedReg[r];
        pend[r] <= 1'b0;
      end else if (wrHit && wrIdx == IDX_W'(r)) begin
        stagedReg[r] <= strobeIn.data & regMask(r);
        pend[r]      <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) calStart <= 1'b0;
    else calStart <= !strobeIn.flush && strobeIn.commit &&
                     (pend[A_FB_LO] || (pend[A_REF] && modeAfter));
  end

  always_comb begin
    if (lookAddr < ADDR_W'(NUM_REGS)) rdData = liveReg[lookAddr[IDX_W-1:0]];
    else rdData = '0;
  end

  assign fbDiv      = {liveReg[A_FB_HI][FB_HI_W-1:0], liveReg[A_FB_LO]};
  assign refDiv     = liveReg[A_REF][REF_W-1:0];
  assign squelchOff = liveReg[A_CTL][SQUELCH_BIT];
  assign calMode    = liveReg[A_CTL][CAL_MODE_BIT];
  assign outCurrent = liveReg[A_CTL][1:0];

  AST_CAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    calStart |=> !calStart); // R8
  AST_CAL_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    calStart |-> $past(strobeIn.commit)); // R9
  AST_LIVE_HELD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !strobeIn.commit |=> $stable(liveReg)); // R2
  AST_SLEEP_NO_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    strobeIn.flush |=> !calStart); // R10
endmodule

// File: rtl/synth_cfg_spi.sv
module synth_cfg_spi
  import synth_cfg_pkg::*;
#(
  parameter int FB_W  = 10,
  parameter int REF_W = 6,
  parameter int CTL_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             runEn,
  input  logic             spiSck,
  input  logic             spiCsN,
  input  logic             spiMosi,
  output logic             spiMisoOut,
  output logic             spiMisoOe,
  output logic [FB_W-1:0]  fbDiv,
  output logic [REF_W-1:0] refDiv,
  output logic             squelchOff,
  output logic             calMode,
  output logic [1:0]       outCurrent,
  output logic             calStart
);
  logic [2:0]        pinsS;
  cfgStrobe_t        strobe;
  logic [ADDR_W-1:0] lookAddr;
  logic [DATA_W-1:0] rdData;

  synth_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .asyncIn({spiMosi, spiCsN, spiSck}),
    .syncOut(pinsS)
  );

  synth_cfg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .runEn(runEn),
    .sckS(pinsS[0]), .csNS(pinsS[1]), .mosiS(pinsS[2]),
    .rdData(rdData), .lookAddr(lookAddr), .strobe(strobe),
    .misoBit(spiMisoOut), .misoOe(spiMisoOe)
  );

  synth_cfg_regs #(.FB_W(FB_W), .REF_W(REF_W), .CTL_W(CTL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .strobeIn(strobe), .lookAddr(lookAddr),
    .rdData(rdData), .fbDiv(fbDiv), .refDiv(refDiv),
    .squelchOff(squelchOff), .calMode(calMode), .outCurrent(outCurrent),
    .calStart(calStart)
  );
endmodule

// File: tb/synth_cfg_spi_bench.sv
module synth_cfg_spi_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic runEn = 1'b1;
  logic spiSck = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic spiMisoOut, spiMisoOe;
  logic [9:0] fbDiv;
  logic [5:0] refDiv;
  logic squelchOff, calMode, calStart;
  logic [1:0] outCurrent;

  int checks = 0, fails = 0;
  int calCount = 0, calWide = 0;
  logic calPrev = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cfg_spi u_synth_cfg_spi (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .spiSck(spiSck), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMisoOut(spiMisoOut), .spiMisoOe(spiMisoOe),
    .fbDiv(fbDiv), .refDiv(refDiv), .squelchOff(squelchOff), .calMode(calMode),
    .outCurrent(outCurrent), .calStart(calStart)
  );

  always @(negedge clk) begin
    if (calStart) calCount++;
    if (calStart && calPrev) calWide++;
    calPrev = calStart;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      spiMosi = tx[7-i];
      waitClk(HALF);
      rx = {rx[6:0], spiMisoOut};
      spiSck = 1'b1;
      waitClk(HALF);
      spiSck = 1'b0;
    end
  endtask

  task automatic frameOpen();
    spiCsN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic frameClose();
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(10);
  endtask

  task automatic pairWr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] rx;
    xfer({1'b0, a}, 8, rx);
    xfer(d, 8, rx);
  endtask

  task automatic pairRd(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] rx;
    xfer({1'b1, a}, 8, rx);
    xfer(8'h00, 8, d);
  endtask

  task automatic readOne(input logic [6:0] a, output logic [7:0] d);
    frameOpen();
    pairRd(a, d);
    frameClose();
  endtask

  task automatic testReset();
    check("R3 fbDiv reset", 32'(fbDiv), 0);
    check("R3 refDiv reset", 32'(refDiv), 0);
    check("R3 ctrl reset", 32'({squelchOff, calMode, outCurrent}), 0);
    check("R7 oe idle", 32'(spiMisoOe), 0);
    check("R8 no cal at reset", 32'(calStart), 0);
  endtask

  task automatic testStagedSingle();
    calCount = 0;
    frameOpen();
    pairWr(7'h01, 8'hFF);
    waitClk(8);
    check("R2 held while select low", 32'(fbDiv), 0);
    frameClose();
    check("R3 addr1 mask", 32'(fbDiv), 32'h300);
    check("R8 no cal for addr1", calCount, 0);
  endtask

  task automatic testBurstWrite();
    calCount = 0; calWide = 0;
    frameOpen();
    pairWr(7'h00, 8'h5A);
    pairWr(7'h02, 8'hFF);
    pairWr(7'h03, 8'hFF);
    check("R2 burst held", 32'({refDiv, fbDiv}), 32'h300);
    frameClose();
    check("R1 R12 fbDiv burst", 32'(fbDiv), 32'h35A);
    check("R12 refDiv masked", 32'(refDiv), 32'h3F);
    check("R12 ctrl fields", 32'({squelchOff, calMode, outCurrent}), 32'hF);
    check("R8 one cal pulse", calCount, 1);
    check("R8 pulse width", calWide, 0);
  endtask

  task automatic testReadBurst();
    logic [7:0] d0, d1, d2, d3, d4;
    frameOpen();
    waitClk(2);
    check("R7 oe in frame", 32'(spiMisoOe), 1);
    pairRd(7'h00, d0);
    pairRd(7'h01, d1);
    pairRd(7'h02, d2);
    pairRd(7'h03, d3);
    pairRd(7'h05, d4);
    frameClose();
    check("R4 read addr0", 32'(d0), 32'h5A);
    check("R4 read addr1", 32'(d1), 32'h03);
    check("R4 read addr2", 32'(d2), 32'h3F);
    check("R4 read addr3", 32'(d3), 32'h0F);
    check("R4 read addr5", 32'(d4), 32'h00);
    check("R7 oe after frame", 32'(spiMisoOe), 0);
  endtask

  task automatic testWriteLowAndBadAddr();
    logic [7:0] ra, rv, d;
    frameOpen();
    xfer(8'h10, 8, ra);
    xfer(8'hFF, 8, rv);
    frameClose();
    check("R6 miso low addr byte", 32'(ra), 0);
    check("R6 miso low value byte", 32'(rv), 0);
    check("R5 high addr no change", 32'({refDiv, fbDiv}), 32'({6'h3F, 10'h35A}));
    readOne(7'h10, d);
    check("R5 high addr reads zero", 32'(d), 0);
  endtask

  task automatic testCalMode();
    calCount = 0;
    frameOpen(); pairWr(7'h02, 8'h07); frameClose();
    check("R9 mode1 addr2 pulses", calCount, 1);
    calCount = 0;
    frameOpen(); pairWr(7'h03, 8'h00); pairWr(7'h02, 8'h05); frameClose();
    check("R9 mode after commit used", calCount, 0);
    check("R9 refDiv applied", 32'(refDiv), 5);
    calCount = 0;
    frameOpen(); pairWr(7'h02, 8'h06); frameClose();
    check("R9 mode0 addr2 no pulse", calCount, 0);
  endtask

  task automatic testReadSeesCommitted();
    logic [7:0] d;
    calCount = 0;
    frameOpen();
    pairWr(7'h00, 8'h11);
    pairRd(7'h00, d);
    frameClose();
    check("R4 read hides staged", 32'(d), 32'h5A);
    readOne(7'h00, d);
    check("R2 value after commit", 32'(d), 32'h11);
    check("R8 addr0 pulse", calCount, 1);
  endtask

  task automatic testPartial();
    logic [7:0] rx;
    calCount = 0;
    frameOpen();
    xfer(8'h00, 8, rx);
    xfer(8'hEE, 4, rx);
    frameClose();
    check("R11 cut byte dropped", 32'(fbDiv[7:0]), 32'h11);
    frameOpen();
    xfer(8'h00, 8, rx);
    frameClose();
    check("R11 lone address dropped", 32'(fbDiv[7:0]), 32'h11);
    check("R11 no cal", calCount, 0);
  endtask

  task automatic testSleepCommitRace();
    logic [7:0] d;
    calCount = 0;
    frameOpen();
    pairWr(7'h00, 8'h77);
    waitClk(HALF);
    runEn = 1'b0;
    spiCsN = 1'b1;
    waitClk(12);
    check("R10 commit dropped in sleep", 32'(fbDiv[7:0]), 32'h11);
    check("R10 no cal in sleep", calCount, 0);
    spiCsN = 1'b0;
    waitClk(6);
    check("R7 oe off asleep", 32'(spiMisoOe), 0);
    spiCsN = 1'b1;
    waitClk(6);
    runEn = 1'b1;
    waitClk(4);
    readOne(7'h00, d);
    check("R10 registers retained", 32'(d), 32'h11);
  endtask

  task automatic testSleepRealign();
    logic [7:0] rx;
    calCount = 0;
    frameOpen();
    xfer(8'hA5, 4, rx);
    runEn = 1'b0;
    waitClk(6);
    runEn = 1'b1;
    waitClk(4);
    pairWr(7'h02, 8'h09);
    frameClose();
    check("R10 shift reset by sleep", 32'(refDiv), 9);
    check("R9 mode0 no pulse", calCount, 0);
  endtask

  initial begin
    waitClk(4);
    rst_n = 1'b1;
    waitClk(4);
    testReset();
    testStagedSingle();
    testBurstWrite();
    testReadBurst();
    testWriteLowAndBadAddr();
    testCalMode();
    testReadSeesCommitted();
    testPartial();
    testSleepCommitRace();
    testSleepRealign();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule